// File: doc/BRIEF.md
# Predicated 32-bit Data-Processing Unit

This block is the execute stage of a small integer datapath. Each cycle it takes a first operand, a second operand that has already been shifted, and the carry that the shifter produced. It also takes a 4-bit operation select, a flag-update request bit, a 4-bit predicate code and the current N, Z, C and V flags. From these it works out a result, a result-write strobe and the flag set for the next instruction. All three outputs are registered, so an instruction presented at one rising edge shows its effect after that edge.

Every operation is predicated. The predicate code is checked against the incoming flags. When the check fails, the instruction still uses its cycle, but the write strobe stays low and the incoming flags pass through unchanged. The four compare/test operations only update flags. The other twelve write a result, and they touch the flags only when the update bit is set. A failed predicate overrides both cases.

Top module: `cond_alu`

## Requirements
- R1: The operation select values are 2 sub (op1−op2), 3 reverse sub (op2−op1), 4 add, 5 add-with-carry (op1+op2+C), 6 sub-with-carry (op1−op2+C−1) and 7 reverse-sub-with-carry (op2−op1+C−1). Each yields its value modulo 2^32 on `res_o`.
- R2: The logical select values are 0 AND, 1 XOR, 12 OR and 14 clear-bits (op1 AND NOT op2). The move values are 13 move (op2) and 15 move-inverted (NOT op2). The move forms ignore op1.
- R3: The compare/test values are 8 (op1 AND op2), 9 (op1 XOR op2), 10 (op1−op2) and 11 (op1+op2). They never raise `wr_o` and always update flags, whatever `set_i` is.
- R4: For all other operations, flags are updated only when `set_i` is 1. Otherwise `flags_o` equals the incoming flags.
- R5: In an arithmetic update, N is result bit 31 and Z is set when the result is zero. C is the carry out, which for subtractions is 1 when no borrow occurs. V is signed overflow of the operation in its selected operand order.
- R6: In a logical, move or test update, C takes `shc_i`, V keeps its incoming value, and N and Z come from the result.
- R7: The flag bus is {N,Z,C,V} at bits 3..0. Predicate codes: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; 10 N==V; 11 N!=V; 12 !Z&(N==V); 13 Z|(N!=V); 14 always.
- R8: Predicate code 15 never executes. Any instruction whose predicate fails leaves `wr_o` low and `flags_o` equal to the incoming flags.
- R9: Outputs change only at a rising clock edge, one cycle after the inputs. While reset is asserted, `res_o`, `wr_o` and `flags_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op1_i | input | 32 | First operand |
| op2_i | input | 32 | Shifted second operand |
| shc_i | input | 1 | Shifter carry-out |
| opc_i | input | 4 | Operation select |
| set_i | input | 1 | Flag-update request |
| cond_i | input | 4 | Predicate code |
| flags_i | input | 4 | Current {N,Z,C,V} |
| res_o | output | 32 | Registered result |
| wr_o | output | 1 | Result-write strobe |
| flags_o | output | 4 | Next {N,Z,C,V} |

## Verification
The bench targets the carry sense of subtraction. A design that used borrow instead of no-borrow would report C=0 on 5−5 and break the unsigned predicates. It covers the reverse and carry-chained subtracts, where swapping operand order or dropping C−1 gives results that are off by one or have the wrong sign. It checks the compare/test forms with `set_i` low, where a design gating them on `set_i` would leave stale flags, and logical updates, where taking V from the adder would corrupt it. A sweep of every operation against every predicate and flag pattern exposes any mis-decoded predicate, including code 15 wrongly treated as always.

// File: rtl/cond_alu_pkg.sv
package cond_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_XOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_OR  = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic is_cmp(alu_op_e op);
    return op[3:2] == 2'b10;
  endfunction
endpackage

// File: rtl/cond_eval.sv
module cond_eval
  import cond_alu_pkg::*;
(
  input  logic [3:0] cond_i,
  input  nzcv_t      fl_i,
  output logic       pass_o
);
  logic base;
  logic n_eq_v;

  assign n_eq_v = (fl_i.n == fl_i.v);

  // bit 0 inverts the even-code test
  always_comb begin
    unique case (cond_i[3:1])
      3'd0: base = fl_i.z;
      3'd1: base = fl_i.c;
      3'd2: base = fl_i.n;
      3'd3: base = fl_i.v;
      3'd4: base = fl_i.c & ~fl_i.z;
      3'd5: base = n_eq_v;
      3'd6: base = ~fl_i.z & n_eq_v;
      default: base = 1'b1;
    endcase
  end

  assign pass_o = (cond_i[3:1] == 3'd7) ? ~cond_i[0] : (base ^ cond_i[0]);
endmodule

// File: rtl/alu_core.sv
module alu_core
  import cond_alu_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] op1_i,
  input  logic [DW-1:0] op2_i,
  input  logic          shc_i,
  input  alu_op_e       opc_i,
  input  nzcv_t         fl_i,
  output logic [DW-1:0] res_o,
  output nzcv_t         fl_o
);
  localparam int unsigned SW = DW + 1;

  logic [DW-1:0] a, b;
  logic          cin;
  logic          arith;
  logic [SW-1:0] sum;

  always_comb begin
    a     = op1_i;
    b     = op2_i;
    cin   = 1'b0;
    arith = 1'b1;
    unique case (opc_i)
      OP_ADD, OP_CMN: ;
      OP_ADC:         cin = fl_i.c;
      OP_SUB, OP_CMP: begin b = ~op2_i; cin = 1'b1;   end
      OP_SBC:         begin b = ~op2_i; cin = fl_i.c; end
      OP_RSB:         begin a = op2_i; b = ~op1_i; cin = 1'b1;   end
      OP_RSC:         begin a = op2_i; b = ~op1_i; cin = fl_i.c; end
      default:        arith = 1'b0;
    endcase
  end

  assign sum = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};

  always_comb begin
    unique case (opc_i)
      OP_AND, OP_TST: res_o = op1_i & op2_i;
      OP_XOR, OP_TEQ: res_o = op1_i ^ op2_i;
      OP_OR:          res_o = op1_i | op2_i;
      OP_BIC:         res_o = op1_i & ~op2_i;
      OP_MOV:         res_o = op2_i;
      OP_MVN:         res_o = ~op2_i;
      default:        res_o = sum[DW-1:0];
    endcase
  end

  always_comb begin
    fl_o.n = res_o[DW-1];
    fl_o.z = (res_o == '0);
    if (arith) begin
      fl_o.c = sum[DW];
      fl_o.v = (a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1]);
    end else begin
      fl_o.c = shc_i;
      fl_o.v = fl_i.v;
    end
  end
endmodule

// File: rtl/cond_alu.sv
module cond_alu
  import cond_alu_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] op1_i,
  input  logic [DW-1:0] op2_i,
  input  logic          shc_i,
  input  logic [3:0]    opc_i,
  input  logic          set_i,
  input  logic [3:0]    cond_i,
  input  logic [3:0]    flags_i,
  output logic [DW-1:0] res_o,
  output logic          wr_o,
  output logic [3:0]    flags_o
);
  alu_op_e       op;
  nzcv_t         fl_cur, fl_new, fl_d;
  logic [DW-1:0] res_d;
  logic          pass, cmp, wr_d, upd;

  assign op     = alu_op_e'(opc_i);
  assign fl_cur = nzcv_t'(flags_i);

  cond_eval u_cond (
    .cond_i (cond_i),
    .fl_i   (fl_cur),
    .pass_o (pass)
  );

  alu_core #(.DW(DW)) u_core (
    .op1_i (op1_i),
    .op2_i (op2_i),
    .shc_i (shc_i),
    .opc_i (op),
    .fl_i  (fl_cur),
    .res_o (res_d),
    .fl_o  (fl_new)
  );

  assign cmp  = is_cmp(op);
  assign wr_d = pass & ~cmp;
  assign upd  = pass & (cmp | set_i);
  assign fl_d = upd ? fl_new : fl_cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      wr_o    <= 1'b0;
      flags_o <= '0;
    end else begin
      res_o   <= res_d;
      wr_o    <= wr_d;
      flags_o <= fl_d;
    end
  end
endmodule

// File: rtl/cond_alu_chk.sv
module cond_alu_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] op2_i,
  input logic [3:0]    opc_i,
  input logic          set_i,
  input logic [3:0]    cond_i,
  input logic [3:0]    flags_i,
  input logic [DW-1:0] res_o,
  input logic          wr_o,
  input logic [3:0]    flags_o
);
  // high once a non-reset edge has captured inputs
  logic live;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live <= 1'b0;
    else         live <= 1'b1;
  end

  AST_CMP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && $past(opc_i[3:2] == 2'b10) |-> !wr_o);  // R3

  AST_NEVER_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && $past(cond_i == 4'hF) |-> !wr_o && flags_o == $past(flags_i));  // R8

  AST_NO_SET_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && $past(!set_i && opc_i[3:2] != 2'b10) |-> flags_o == $past(flags_i));  // R4

  AST_LOGIC_V_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && $past(opc_i inside {4'd0, 4'd1, 4'd8, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15})
    |-> flags_o[0] == $past(flags_i[0]));  // R6

  AST_MOVE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && $past(opc_i == 4'd13) |-> res_o == $past(op2_i));  // R2

  AST_ALWAYS_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && $past(cond_i == 4'hE && opc_i[3:2] != 2'b10) |-> wr_o);  // R7

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> res_o == '0 && !wr_o && flags_o == 4'h0);  // R9
endmodule

bind cond_alu cond_alu_chk #(.DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .op2_i   (op2_i),
  .opc_i   (opc_i),
  .set_i   (set_i),
  .cond_i  (cond_i),
  .flags_i (flags_i),
  .res_o   (res_o),
  .wr_o    (wr_o),
  .flags_o (flags_o)
);

// File: tb/cond_alu_test.sv
module cond_alu_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] op1_i = '0, op2_i = '0;
  logic        shc_i = 1'b0, set_i = 1'b0;
  logic [3:0]  opc_i = '0, cond_i = '0, flags_i = '0;
  logic [31:0] res_o;
  logic        wr_o;
  logic [3:0]  flags_o;

  int nvec = 0;
  int nbad = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  cond_alu uut (
    .clk_i, .rst_ni, .op1_i, .op2_i, .shc_i, .opc_i,
    .set_i, .cond_i, .flags_i, .res_o, .wr_o, .flags_o
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  opc;
    logic [3:0]  cnd;
    logic        s;
    logic [3:0]  fl;
    logic [31:0] a;
    logic [31:0] b;
    logic        sc;
    logic [31:0] er;
    logic        ew;
    logic [3:0]  ef;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    {4'd5, 4'h4, 4'hE, 1'b1, 4'h0, 32'hFFFFFFFF, 32'h1, 1'b0, 32'h0, 1'b1, 4'h6},         // R5 add carry, zero
    {4'd5, 4'h2, 4'hE, 1'b1, 4'h0, 32'h5, 32'h5, 1'b0, 32'h0, 1'b1, 4'h6},                // R5 sub no borrow
    {4'd5, 4'h2, 4'hE, 1'b1, 4'h0, 32'h3, 32'h5, 1'b0, 32'hFFFFFFFE, 1'b1, 4'h8},         // R5 sub borrow
    {4'd5, 4'h4, 4'hE, 1'b1, 4'h0, 32'h7FFFFFFF, 32'h1, 1'b0, 32'h80000000, 1'b1, 4'h9},  // R5 overflow
    {4'd1, 4'h3, 4'hE, 1'b1, 4'h0, 32'h1, 32'hA, 1'b0, 32'h9, 1'b1, 4'h2},                // R1 reverse sub
    {4'd1, 4'h6, 4'hE, 1'b1, 4'h0, 32'hA, 32'h3, 1'b0, 32'h6, 1'b1, 4'h2},                // R1 sub with C=0
    {4'd1, 4'h7, 4'hE, 1'b1, 4'h2, 32'hA, 32'h3, 1'b0, 32'hFFFFFFF9, 1'b1, 4'h8},         // R1 rsc with C=1
    {4'd4, 4'h5, 4'hE, 1'b0, 4'h2, 32'h1, 32'h1, 1'b0, 32'h3, 1'b1, 4'h2},                // R4 adc, no set
    {4'd6, 4'hE, 4'hE, 1'b1, 4'h1, 32'hFF00FF00, 32'h0F0F0F0F, 1'b1, 32'hF000F000, 1'b1, 4'hB}, // R6 clear-bits
    {4'd2, 4'hF, 4'hE, 1'b1, 4'h0, 32'h1234, 32'hFFFFFFFF, 1'b0, 32'h0, 1'b1, 4'h4},      // R2 move-inverted
    {4'd3, 4'hA, 4'hE, 1'b0, 4'h0, 32'h4, 32'h4, 1'b0, 32'h0, 1'b0, 4'h6},                // R3 compare, S=0
    {4'd3, 4'h8, 4'hE, 1'b0, 4'h9, 32'hF0, 32'h0F, 1'b1, 32'h0, 1'b0, 4'h7},              // R3 test, S=0
    {4'd8, 4'h4, 4'h0, 1'b1, 4'h0, 32'h1, 32'h1, 1'b0, 32'h2, 1'b0, 4'h0},                // R8 failed predicate
    {4'd8, 4'hD, 4'hF, 1'b1, 4'h4, 32'h0, 32'h55, 1'b0, 32'h55, 1'b0, 4'h4},              // R8 code 15 never
    {4'd7, 4'hC, 4'hC, 1'b0, 4'h9, 32'h1, 32'h2, 1'b0, 32'h3, 1'b1, 4'h9},                // R7 greater passes
    {4'd7, 4'h1, 4'hD, 1'b1, 4'h8, 32'hF, 32'hF, 1'b0, 32'h0, 1'b1, 4'h4},                // R7 less-equal passes
    {4'd3, 4'hB, 4'hE, 1'b0, 4'h0, 32'h80000000, 32'h80000000, 1'b0, 32'h0, 1'b0, 4'h7}, // R3 compare-add
    {4'd6, 4'h9, 4'hE, 1'b0, 4'h8, 32'h5, 32'h5, 1'b0, 32'h0, 1'b0, 4'h4}                 // R6 test-xor
  };

  // independent model built from the requirement text; returns {wr, flags, res}
  function automatic logic [36:0] model(logic [3:0] opc, logic [3:0] cnd, logic s,
                                        logic [3:0] fl, logic [31:0] a, logic [31:0] b,
                                        logic sc);
    logic n = fl[3], z = fl[2], c = fl[1], v = fl[0];
    logic ok, ar, nc, nv;
    logic [31:0] r;
    longint ua = longint'(a), ub = longint'(b);
    longint sa = longint'($signed(a)), sb = longint'($signed(b));
    longint cu = longint'(c), t, st;
    case (cnd)
      4'd0: ok = z;              4'd1: ok = !z;
      4'd2: ok = c;              4'd3: ok = !c;
      4'd4: ok = n;              4'd5: ok = !n;
      4'd6: ok = v;              4'd7: ok = !v;
      4'd8: ok = c && !z;        4'd9: ok = !c || z;
      4'd10: ok = (n == v);      4'd11: ok = (n != v);
      4'd12: ok = !z && (n == v); 4'd13: ok = z || (n != v);
      4'd14: ok = 1'b1;          default: ok = 1'b0;
    endcase
    ar = 1'b1; t = 0; st = 0; nc = sc; nv = v;
    case (opc)
      4'd4, 4'd11: begin t = ua + ub;          st = sa + sb;          nc = t >= 64'sh100000000; end
      4'd5:        begin t = ua + ub + cu;     st = sa + sb + cu;     nc = t >= 64'sh100000000; end
      4'd2, 4'd10: begin t = ua - ub;          st = sa - sb;          nc = ua >= ub; end
      4'd6:        begin t = ua - ub + cu - 1; st = sa - sb + cu - 1; nc = ua >= ub + 1 - cu; end
      4'd3:        begin t = ub - ua;          st = sb - sa;          nc = ub >= ua; end
      4'd7:        begin t = ub - ua + cu - 1; st = sb - sa + cu - 1; nc = ub >= ua + 1 - cu; end
      default: ar = 1'b0;
    endcase
    case (opc)
      4'd0, 4'd8: r = a & b;
      4'd1, 4'd9: r = a ^ b;
      4'd12:      r = a | b;
      4'd13:      r = b;
      4'd14:      r = a & ~b;
      4'd15:      r = ~b;
      default:    r = t[31:0];
    endcase
    if (ar) nv = (st > 64'sd2147483647) || (st < -64'sd2147483648);
    else    nc = sc;
    if (!ok)                                return {1'b0, fl, r};
    if (opc >= 4'd8 && opc <= 4'd11)        return {1'b0, r[31], r == 0, nc, nv, r};
    if (s)                                  return {1'b1, r[31], r == 0, nc, nv, r};
    return {1'b1, fl, r};
  endfunction

  task automatic check(string tag, logic [31:0] er, logic ew, logic [3:0] ef);
    nvec++;
    if (res_o !== er || wr_o !== ew || flags_o !== ef) begin
      nbad++;
      $display("FAIL %s: got res=%h wr=%b fl=%h, want res=%h wr=%b fl=%h",
               tag, res_o, wr_o, flags_o, er, ew, ef);
    end
  endtask

  // called at a negedge: drive, cross one rising edge, sample at next negedge
  task automatic apply(logic [3:0] opc, logic [3:0] cnd, logic s, logic [3:0] fl,
                       logic [31:0] a, logic [31:0] b, logic sc);
    opc_i = opc; cond_i = cnd; set_i = s; flags_i = fl;
    op1_i = a; op2_i = b; shc_i = sc;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #800000;
    nbad++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [36:0] m;
    // R9 reset state with busy inputs
    opc_i = 4'h4; cond_i = 4'hE; set_i = 1'b1; op1_i = 32'h7; op2_i = 32'h9; flags_i = 4'hF;
    repeat (3) @(negedge clk_i);
    check("R9 reset", 32'h0, 1'b0, 4'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    foreach (TBL[i]) begin
      apply(TBL[i].opc, TBL[i].cnd, TBL[i].s, TBL[i].fl, TBL[i].a, TBL[i].b, TBL[i].sc);
      check($sformatf("R%0d vec %0d", TBL[i].req, i), TBL[i].er, TBL[i].ew, TBL[i].ef);
    end

    // R9 one-cycle latency: new inputs invisible before the edge
    apply(4'hD, 4'hE, 1'b0, 4'h0, 32'h0, 32'hABCD, 1'b0);
    opc_i = 4'hD; op2_i = 32'h1357;
    #1 check("R9 hold before edge", 32'hABCD, 1'b1, 4'h0);
    @(negedge clk_i);
    check("R9 update after edge", 32'h1357, 1'b1, 4'h0);

    // R2 move ignores op1
    apply(4'hD, 4'hE, 1'b1, 4'h0, 32'hDEADBEEF, 32'h80000000, 1'b1);
    check("R2 move op1 ignored", 32'h80000000, 1'b1, 4'hA);

    // R1 R3 R4 R5 R6 R7 R8 full sweep
    for (int op = 0; op < 16; op++)
      for (int cd = 0; cd < 16; cd++)
        for (int f = 0; f < 16; f++)
          for (int k = 0; k < 2; k++) begin
            logic [31:0] a = k ? 32'h80000001 : 32'h00000010;
            logic [31:0] b = k ? 32'h7FFFFFFF : 32'h00000010;
            logic s = f[0] ^ k[0];
            logic sc = f[1] ^ op[0];
            m = model(op[3:0], cd[3:0], s, f[3:0], a, b, sc);
            apply(op[3:0], cd[3:0], s, f[3:0], a, b, sc);
            check($sformatf("R7 sweep op=%0d cond=%0d fl=%h", op, cd, f),
                  m[31:0], m[36], m[35:32]);
          end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule